// File: doc/BRIEF.md
# Write-Once Flash Clock Prescaler

This block turns the bus clock into a slow timebase for a flash command engine. It does not make a second clock. It sends a one-cycle enable pulse, `tick`, once per divided period. The command sequencer counts these pulses to time its program and erase steps, so the whole design stays in the bus clock domain. Software picks the period by writing a divide value and an optional divide-by-eight pre-stage select. The resulting rate should fall between 150 kHz and 200 kHz.

The divider setting can be stored only once after reset. The first accepted write locks it, and all later writes are dropped. A write made while the access-error input is high is refused. That refused write does not use up the single write. Until a value has been stored, the `loaded` status stays low, no ticks are produced and every command request is blocked.

The asynchronous reset is applied at once, but its release passes through a two-stage synchronizer before it reaches the internal state.

Top module: `flash_tick_prescaler`

## Requirements
- R1: While reset is held and just after it is released, `loaded`, `rd_div`, `rd_pre`, `tick` and `cmd_accept` are all 0.
- R2: A write (`wr_en` high on a clock edge) with `acc_err` low and `loaded` low stores `wr_div` and `wr_pre`. From the next cycle, `rd_div`/`rd_pre` show the stored values and `loaded` reads 1.
- R3: Once `loaded` is 1, every further write is ignored: `rd_div`, `rd_pre` and the tick period stay unchanged.
- R4: A write on an edge where `acc_err` is 1 changes nothing. `loaded` stays 0 and a later write with `acc_err` low is still accepted.
- R5: `loaded` stays 1 until the next reset, and a reset returns it and the stored value to 0.
- R6: `cmd_accept` is 1 exactly when `cmd_req` is 1 and `loaded` is 1.
- R7: While `loaded` is 0, `tick` never goes high.
- R8: While loaded, rising `tick` pulses repeat every (P × (D+1)) bus cycles. D is the stored 6-bit divide value. P is 8 when the stored pre-select bit is 1, and 1 when it is 0.
- R9: When the period is longer than one cycle, `tick` is high for exactly one cycle. With D=0 and the pre-select bit at 0, `tick` stays high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Divider register write strobe |
| wr_div | input | DIV_W | Divide value to store |
| wr_pre | input | 1 | Pre-stage select to store (1 = divide by PRE_FACTOR) |
| acc_err | input | 1 | Access-error flag; a write is refused while it is high |
| cmd_req | input | 1 | Command request from the sequencer |
| cmd_accept | output | 1 | Command request allowed (request and loaded) |
| loaded | output | 1 | Divider register has been written since reset |
| rd_div | output | DIV_W | Stored divide value |
| rd_pre | output | 1 | Stored pre-stage select |
| tick | output | 1 | One-cycle timebase enable pulse |

## Verification
The bench builds the block with its default parameters: a 6-bit divide field and a pre-stage factor of eight. With these values the full range of periods can be reached in a short run, from the one-cycle case (D=0, no pre-stage) up to the 512-cycle maximum (D=63 with the pre-stage). Because the register can be written only once, each setting is tested after a fresh reset. This lets the lock, the error refusal and the reset clearing each be observed in isolation.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
  localparam int unsigned DEF_DIV_W      = 6;
  localparam int unsigned DEF_PRE_FACTOR = 8;
endpackage

// File: rtl/ftp_rst_sync.sv
module ftp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sh_q;
  logic [1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[1];
endmodule

// File: rtl/ftp_cfg_reg.sv
module ftp_cfg_reg #(
  parameter int unsigned DIV_W = ftp_pkg::DEF_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             wr_pre,
  input  logic             acc_err,
  output logic [DIV_W-1:0] div_q,
  output logic             pre_q,
  output logic             loaded_q
);
  logic             accept;
  logic [DIV_W-1:0] div_d;
  logic             pre_d;
  logic             loaded_d;

  // one-time write: refused while the error flag is up or once locked
  always_comb begin
    accept   = wr_en && !acc_err && !loaded_q;
    div_d    = div_q;
    pre_d    = pre_q;
    loaded_d = loaded_q;
    if (accept) begin
      div_d    = wr_div;
      pre_d    = wr_pre;
      loaded_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      pre_q    <= 1'b0;
      loaded_q <= 1'b0;
    end else if (accept) begin
      div_q    <= div_d;
      pre_q    <= pre_d;
      loaded_q <= loaded_d;
    end
  end
endmodule

// File: rtl/ftp_tick_gen.sv
module ftp_tick_gen #(
  parameter int unsigned DIV_W      = ftp_pkg::DEF_DIV_W,
  parameter int unsigned PRE_FACTOR = ftp_pkg::DEF_PRE_FACTOR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             pre,
  output logic             tick
);
  logic             stg;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             tick_d;

  generate
    if (PRE_FACTOR > 1) begin : g_pre
      localparam int unsigned PRE_W = $clog2(PRE_FACTOR);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_FACTOR - 1);
      logic [PRE_W-1:0] pc_q;
      logic [PRE_W-1:0] pc_d;

      always_comb begin
        if (!run || !pre)        pc_d = '0;
        else if (pc_q == PRE_LAST) pc_d = '0;
        else                     pc_d = pc_q + 1'b1;
        stg = !pre || (pc_q == PRE_LAST);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
      end
    end else begin : g_nopre
      logic unused_pre;
      assign unused_pre = pre;
      assign stg = 1'b1;
    end
  endgenerate

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else if (stg) begin
      if (cnt_q == div) begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tick  <= tick_d;
    end
  end
endmodule

// File: rtl/flash_tick_prescaler.sv
module flash_tick_prescaler #(
  parameter int unsigned DIV_W      = ftp_pkg::DEF_DIV_W,
  parameter int unsigned PRE_FACTOR = ftp_pkg::DEF_PRE_FACTOR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             wr_pre,
  input  logic             acc_err,
  input  logic             cmd_req,
  output logic             cmd_accept,
  output logic             loaded,
  output logic [DIV_W-1:0] rd_div,
  output logic             rd_pre,
  output logic             tick
);
  logic srst_n;

  ftp_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ftp_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_en    (wr_en),
    .wr_div   (wr_div),
    .wr_pre   (wr_pre),
    .acc_err  (acc_err),
    .div_q    (rd_div),
    .pre_q    (rd_pre),
    .loaded_q (loaded)
  );

  ftp_tick_gen #(.DIV_W(DIV_W), .PRE_FACTOR(PRE_FACTOR)) u_tick (
    .clk   (clk),
    .rst_n (srst_n),
    .run   (loaded),
    .div   (rd_div),
    .pre   (rd_pre),
    .tick  (tick)
  );

  // commands gated until the timebase is configured
  assign cmd_accept = cmd_req && loaded;
endmodule

// File: rtl/ftp_checker.sv
module ftp_checker #(
  parameter int unsigned DIV_W      = ftp_pkg::DEF_DIV_W,
  parameter int unsigned PRE_FACTOR = ftp_pkg::DEF_PRE_FACTOR
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             acc_err,
  input logic             cmd_req,
  input logic             cmd_accept,
  input logic             loaded,
  input logic [DIV_W-1:0] rd_div,
  input logic             rd_pre,
  input logic             tick
);
  logic [31:0] since_q;
  logic        seen_q;
  logic [31:0] exp_per;
  logic        per_one;

  always_comb begin
    exp_per = (rd_pre ? 32'(PRE_FACTOR) : 32'd1) * (32'(rd_div) + 32'd1);
    per_one = (exp_per == 32'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (tick) begin
      since_q <= 32'd1;
      seen_q  <= 1'b1;
    end else if (since_q != 32'hFFFF_FFFF) begin
      since_q <= since_q + 32'd1;
    end
  end

  p_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen_q) |-> (since_q == exp_per));

  p_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !per_one) |=> !tick);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded);

  p_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> ($stable(rd_div) && $stable(rd_pre)));

  p_err_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_err && !loaded) |=> !loaded);

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |-> (loaded && cmd_req));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> !tick);
endmodule

bind flash_tick_prescaler ftp_checker #(.DIV_W(DIV_W), .PRE_FACTOR(PRE_FACTOR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .acc_err    (acc_err),
  .cmd_req    (cmd_req),
  .cmd_accept (cmd_accept),
  .loaded     (loaded),
  .rd_div     (rd_div),
  .rd_pre     (rd_pre),
  .tick       (tick)
);

// File: tb/sim_flash_tick_prescaler.sv
`timescale 1ns/1ps
module sim_flash_tick_prescaler;
  localparam int DW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_div = '0;
  logic          wr_pre = 1'b0;
  logic          acc_err = 1'b0;
  logic          cmd_req = 1'b0;
  logic          cmd_accept;
  logic          loaded;
  logic [DW-1:0] rd_div;
  logic          rd_pre;
  logic          tick;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_tick_prescaler u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_div(wr_div), .wr_pre(wr_pre),
    .acc_err(acc_err), .cmd_req(cmd_req), .cmd_accept(cmd_accept),
    .loaded(loaded), .rd_div(rd_div), .rd_pre(rd_pre), .tick(tick)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; acc_err = 1'b0; cmd_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_cfg(input int d, input bit p);
    @(negedge clk);
    wr_en = 1'b1; wr_div = DW'(d); wr_pre = p;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // cycles between two rising edges of tick, sampled at negedges
  task automatic measure(output int per);
    int guard;
    per = -1;
    guard = 0;
    while (tick !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
    if (tick === 1'b1) begin
      per = 0;
      do begin @(negedge clk); per++; end while (tick !== 1'b1 && per < 2000);
    end
  endtask

  task automatic t_reset_state();
    int hits;
    do_reset();
    check("R1", "loaded", int'(loaded), 0);
    check("R1", "rd_div", int'(rd_div), 0);
    check("R1", "rd_pre", int'(rd_pre), 0);
    cmd_req = 1'b1;
    #1;
    check("R6", "cmd_accept unloaded", int'(cmd_accept), 0);
    hits = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (tick) hits++; end
    check("R7", "ticks while unloaded", hits, 0);
    cmd_req = 1'b0;
  endtask

  task automatic t_basic_and_lock();
    int per;
    do_reset();
    write_cfg(4, 1'b0);
    check("R2", "loaded", int'(loaded), 1);
    check("R2", "rd_div", int'(rd_div), 4);
    check("R2", "rd_pre", int'(rd_pre), 0);
    cmd_req = 1'b1; #1;
    check("R6", "cmd_accept loaded", int'(cmd_accept), 1);
    cmd_req = 1'b0; #1;
    check("R6", "cmd_accept no req", int'(cmd_accept), 0);
    measure(per);
    check("R8", "period d4 p0", per, 5);
    @(negedge clk);
    check("R9", "tick low after pulse", int'(tick), 0);
    write_cfg(9, 1'b1);
    check("R3", "rd_div after 2nd write", int'(rd_div), 4);
    check("R3", "rd_pre after 2nd write", int'(rd_pre), 0);
    measure(per);
    check("R3", "period after 2nd write", per, 5);
    repeat (50) @(negedge clk);
    check("R5", "loaded held", int'(loaded), 1);
    do_reset();
    check("R5", "loaded after reset", int'(loaded), 0);
    check("R5", "rd_div after reset", int'(rd_div), 0);
  endtask

  task automatic t_err_refuse();
    int per;
    do_reset();
    acc_err = 1'b1;
    write_cfg(7, 1'b0);
    check("R4", "loaded with err", int'(loaded), 0);
    check("R4", "rd_div with err", int'(rd_div), 0);
    acc_err = 1'b0;
    write_cfg(2, 1'b1);
    check("R4", "loaded after err clears", int'(loaded), 1);
    check("R4", "rd_div after err clears", int'(rd_div), 2);
    measure(per);
    check("R8", "period d2 p1", per, 24);
  endtask

  task automatic t_extremes();
    int per;
    int highs;
    do_reset();
    write_cfg(63, 1'b1);
    measure(per);
    check("R8", "period d63 p1", per, 512);
    do_reset();
    write_cfg(0, 1'b1);
    measure(per);
    check("R8", "period d0 p1", per, 8);
    do_reset();
    write_cfg(0, 1'b0);
    repeat (3) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (tick) highs++; end
    check("R9", "continuous tick d0 p0", highs, 10);
    measure(per);
    check("R8", "period d0 p0", per, 1);
  endtask

  initial begin
    while (!done && cyc < 200000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_basic_and_lock();
    t_err_refuse();
    t_extremes();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule